// File: doc/BRIEF.md
# Buffered Multiplexed-Bus Write Engine

This block sits between a processor core and a shared multiplexed address/data bus. It handles every outbound write: dirty-line writebacks, uncached stores and write-through stores. The core hands over address/data pairs of 64 bits each, together with a byte mask. They are held in a four-entry first-in first-out buffer, so the core can continue working while the bus drains them.

The bus side sends each buffered write as one transaction. A transaction is a single address cycle, then a configurable number of idle gap cycles, then one or more data cycles. Every bus cycle carries even byte-lane check bits. Three settings are captured while reset is held and stay fixed until the next reset:

- the bus width, either 64-bit wide or 32-bit narrow;
- the gap length, from 0 to 7 cycles;
- whether pipelined issue is enabled.

In narrow mode, data that spans both halves of a double word is re-split into word-sized beats or separate transactions. A write-ready input gates when a new transaction may start. In pipelined mode one further transaction may start after write-ready falls.

Top module: `wbuf_bus_writer`

## Requirements
- R1: The buffer holds at most 4 entries. `in_ready` is 1 exactly while fewer than 4 entries are held. After reset the buffer is empty, `in_ready` is 1 and `bus_valid` is 0.
- R2: Entries leave the buffer in the order they were accepted.
- R3: Between a transaction's address cycle and its first data cycle there are exactly G cycles with `bus_valid` low, where G is the captured gap setting. This holds for single writes and for line writes.
- R4: In wide mode a single write is one address cycle followed by one data cycle. The address cycle has `bus_addr_cyc`=1, carries the entry address on `bus_ad` and the entry byte mask on `bus_be`. The data cycle has `bus_addr_cyc`=0, carries all 64 data bits and keeps the same mask.
- R5: An entry marked as a line part (`in_line`=1) is only sent once 4 entries are held. The line goes out as one transaction:
  - one address cycle with `bus_line`=1, carrying the first entry's address;
  - in wide mode, 4 back-to-back data beats with mask 0xFF, one per entry;
  - in narrow mode, 8 back-to-back beats with mask 0x0F, giving each entry's bits 31:0 and then its bits 63:32.
- R6: In narrow mode a single write is handled by which mask halves it uses:
  - If its mask has bytes in both halves, it becomes two transactions. The first is at the entry address with address bit 2 cleared, carrying data bits 31:0 and mask bits 3:0. The second is at the address with bit 2 set, carrying data bits 63:32 and mask bits 7:4 moved down to bits 3:0.
  - A mask using only one half gives a single transaction for that half.
- R7: On every valid cycle, `bus_chk[i]` equals the XOR of the eight bits `bus_ad[8i+7:8i]`, which is even parity per byte lane. In narrow mode, data beats carry zero on `bus_ad[63:32]`, so `bus_chk[7:4]` is 0.
- R8: With pipelined issue off, an address cycle follows only a clock edge at which `bus_wr_rdy` was 1. The data beats of a transaction already started still complete.
- R9: With pipelined issue on, once `bus_wr_rdy` has been seen at 1, exactly one transaction may start while it is 0. The allowance returns when `bus_wr_rdy` is seen at 1 again.
- R10: With gap 0 and `bus_wr_rdy` held at 1, successive single-write address cycles are 2 cycles apart.
- R11: `cfg_wide`, `cfg_gap` and `cfg_pipe` are sampled only while `rst` is 1. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; configuration captured while high |
| cfg_wide | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| cfg_gap | input | 3 | Idle cycles between address cycle and first data cycle |
| cfg_pipe | input | 1 | 1 = one extra transaction allowed after write-ready falls |
| in_valid | input | 1 | Core offers a write |
| in_ready | output | 1 | Buffer can take the offered write |
| in_addr | input | 64 | Double-word address of the write |
| in_data | input | 64 | Write data |
| in_be | input | 8 | Byte mask, bit i enables byte lane i |
| in_line | input | 1 | Entry is one quarter of a line writeback |
| bus_wr_rdy | input | 1 | Bus can take a new write |
| bus_valid | output | 1 | Bus cycle carries an address or data |
| bus_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| bus_line | output | 1 | Current transaction is a line block |
| bus_be | output | 8 | Byte mask of the current transaction |
| bus_ad | output | 64 | Multiplexed address/data |
| bus_chk | output | 8 | Even parity bit per byte lane of bus_ad |

## Verification
Two events can fall in the same clock edge. A core push can arrive at the edge where the bus side pops an entry. Write-ready can also fall at the edge where the engine returns to idle. The bench provokes the first by pushing single writes on consecutive cycles while the issuer drains at its 2-cycle rate. It judges the result by the order of data beats and the spacing of address cycles in a captured bus log. It provokes the second by raising write-ready for exactly one cycle with writes queued. It then counts the address cycles that follow, expecting one with pipelined issue off and two with it on.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WB_AW = 64;
  localparam int WB_DW = 64;
  localparam int WB_BW = WB_DW / 8;

  typedef struct packed {
    logic              line;
    logic [WB_BW-1:0]  be;
    logic [WB_AW-1:0]  addr;
    logic [WB_DW-1:0]  data;
  } wb_entry_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_DATA = 2'd2
  } wb_phase_t;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  wb_entry_t        push_ent,
  input  logic             pop,
  output wb_entry_t        head,
  output logic [CNT_W-1:0] count
);
  wb_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset so that it maps to distributed or block memory
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  // the issuer never drains an empty buffer (R2)
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/wbuf_parity.sv
module wbuf_parity #(
  parameter int DW = 64,
  localparam int LANES = DW / 8
) (
  input  logic [DW-1:0]    ad,
  output logic [LANES-1:0] chk
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign chk[i] = ^ad[8*i +: 8];
  end
endmodule

// File: rtl/wbuf_issuer.sv
module wbuf_issuer
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int GAP_W = 3,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BEAT_W = $clog2(2 * DEPTH),
  localparam int HALF_W = WB_DW / 2,
  localparam int LANE_LSB = $clog2(WB_BW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wide,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_pipe,
  input  wb_entry_t         head,
  input  logic [CNT_W-1:0]  count,
  output logic              pop,
  input  logic              wr_rdy,
  output logic              bus_valid,
  output logic              bus_addr_cyc,
  output logic              bus_line,
  output logic [WB_BW-1:0]  bus_be,
  output logic [WB_AW-1:0]  bus_ad
);
  logic             wide_q, pipe_q;
  logic [GAP_W-1:0] gap_q, gap_cnt;
  wb_phase_t        phase;
  logic [BEAT_W-1:0] beat, last_beat;
  logic             line_q, hi_q, sgl_last_q, split_pend, xtra_ok;

  logic             have, may_start, use_hi, last_half, half_sel;
  logic [HALF_W-1:0] word;
  logic [WB_DW-1:0] beat_ad;
  logic [WB_AW-1:0] narrow_addr;
  logic [WB_BW-1:0] narrow_be;

  always_comb begin
    have      = (count != '0) && (!head.line || count == CNT_W'(DEPTH));
    may_start = wr_rdy || (pipe_q && xtra_ok);
    use_hi    = split_pend || !(|head.be[WB_BW/2-1:0]);
    last_half = use_hi || !(|head.be[WB_BW-1:WB_BW/2]);
    narrow_addr = {head.addr[WB_AW-1:LANE_LSB], use_hi, {(LANE_LSB-1){1'b0}}};
    narrow_be   = use_hi ? {{(WB_BW/2){1'b0}}, head.be[WB_BW-1:WB_BW/2]}
                         : {{(WB_BW/2){1'b0}}, head.be[WB_BW/2-1:0]};
    half_sel  = line_q ? beat[0] : hi_q;
    word      = half_sel ? head.data[WB_DW-1:HALF_W] : head.data[HALF_W-1:0];
    beat_ad   = wide_q ? head.data : {{HALF_W{1'b0}}, word};
    if (!line_q)     last_beat = '0;
    else if (wide_q) last_beat = BEAT_W'(DEPTH - 1);
    else             last_beat = BEAT_W'(2 * DEPTH - 1);
    pop = (phase == PH_DATA) && (line_q ? (wide_q || beat[0]) : sgl_last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q       <= cfg_wide;
      gap_q        <= cfg_gap;
      pipe_q       <= cfg_pipe;
      phase        <= PH_IDLE;
      gap_cnt      <= '0;
      beat         <= '0;
      line_q       <= 1'b0;
      hi_q         <= 1'b0;
      sgl_last_q   <= 1'b0;
      split_pend   <= 1'b0;
      xtra_ok      <= 1'b0;
      bus_valid    <= 1'b0;
      bus_addr_cyc <= 1'b0;
      bus_line     <= 1'b0;
      bus_be       <= '0;
      bus_ad       <= '0;
    end else begin
      bus_valid    <= 1'b0;
      bus_addr_cyc <= 1'b0;
      if (wr_rdy) xtra_ok <= 1'b1;
      case (phase)
        PH_IDLE: begin
          if (have && may_start) begin
            if (!wr_rdy) xtra_ok <= 1'b0;
            bus_valid    <= 1'b1;
            bus_addr_cyc <= 1'b1;
            bus_line     <= head.line;
            line_q       <= head.line;
            beat         <= '0;
            gap_cnt      <= gap_q;
            phase        <= (gap_q == '0) ? PH_DATA : PH_GAP;
            if (wide_q) begin
              bus_ad     <= head.addr;
              bus_be     <= head.line ? '1 : head.be;
              hi_q       <= 1'b0;
              sgl_last_q <= 1'b1;
            end else begin
              bus_ad     <= head.line ? head.addr : narrow_addr;
              bus_be     <= head.line ? {{(WB_BW/2){1'b0}}, {(WB_BW/2){1'b1}}}
                                      : narrow_be;
              hi_q       <= use_hi;
              sgl_last_q <= last_half;
            end
          end
        end
        PH_GAP: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == GAP_W'(1)) phase <= PH_DATA;
        end
        PH_DATA: begin
          bus_valid <= 1'b1;
          bus_ad    <= beat_ad;
          beat      <= beat + 1'b1;
          if (beat == last_beat) begin
            phase <= PH_IDLE;
            if (!line_q && !wide_q) split_pend <= !sgl_last_q;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: gap of zero puts the first data beat right after the address cycle
  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr_cyc && gap_q == '0) |=> (bus_valid && !bus_addr_cyc));
  // R3: a nonzero gap leaves the bus idle after the address cycle
  assert_gap_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr_cyc && gap_q != '0) |=> !bus_valid);
  // R8: without pipelined issue, an address cycle needs write-ready at its edge
  assert_rdy_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr_cyc && !pipe_q) |-> $past(wr_rdy));
  // R7: narrow data beats leave the upper half of the bus at zero
  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_addr_cyc && !wide_q) |-> (bus_ad[WB_DW-1:HALF_W] == '0));
endmodule

// File: rtl/wbuf_bus_writer.sv
module wbuf_bus_writer
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int GAP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wide,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_pipe,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WB_AW-1:0]  in_addr,
  input  logic [WB_DW-1:0]  in_data,
  input  logic [WB_BW-1:0]  in_be,
  input  logic              in_line,
  input  logic              bus_wr_rdy,
  output logic              bus_valid,
  output logic              bus_addr_cyc,
  output logic              bus_line,
  output logic [WB_BW-1:0]  bus_be,
  output logic [WB_AW-1:0]  bus_ad,
  output logic [WB_BW-1:0]  bus_chk
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        push_ent, head;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign in_ready = (count != CNT_W'(DEPTH));
  assign push     = in_valid && in_ready;
  assign push_ent = '{line: in_line, be: in_be, addr: in_addr, data: in_data};

  wbuf_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push(push), .push_ent(push_ent),
    .pop(pop), .head(head), .count(count)
  );

  wbuf_issuer #(.DEPTH(DEPTH), .GAP_W(GAP_W)) i_issuer (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_gap(cfg_gap),
    .cfg_pipe(cfg_pipe), .head(head), .count(count), .pop(pop),
    .wr_rdy(bus_wr_rdy), .bus_valid(bus_valid), .bus_addr_cyc(bus_addr_cyc),
    .bus_line(bus_line), .bus_be(bus_be), .bus_ad(bus_ad)
  );

  wbuf_parity #(.DW(WB_DW)) i_parity (.ad(bus_ad), .chk(bus_chk));

  // R1: a full buffer refuses the core
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(count) == CNT_W'(DEPTH) && !$past(pop)) |-> !in_ready);
endmodule

// File: tb/test_wbuf_bus_writer.sv
module test_wbuf_bus_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b1, cfg_pipe = 1'b0;
  logic [2:0]  cfg_gap = 3'd0;
  logic        in_valid = 1'b0, in_line = 1'b0, bus_wr_rdy = 1'b0;
  logic [63:0] in_addr = '0, in_data = '0;
  logic [7:0]  in_be = '0;
  logic        in_ready, bus_valid, bus_addr_cyc, bus_line;
  logic [7:0]  bus_be, bus_chk;
  logic [63:0] bus_ad;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [63:0] lg_ad [128];
  logic [7:0]  lg_be [128];
  logic [7:0]  lg_chk[128];
  logic        lg_adr[128];
  logic        lg_ln [128];
  int          lg_cy [128];
  int          lg_n = 0;

  always #5 clk = ~clk;

  wbuf_bus_writer i_wbuf_bus_writer (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_gap(cfg_gap),
    .cfg_pipe(cfg_pipe), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be), .in_line(in_line),
    .bus_wr_rdy(bus_wr_rdy), .bus_valid(bus_valid), .bus_addr_cyc(bus_addr_cyc),
    .bus_line(bus_line), .bus_be(bus_be), .bus_ad(bus_ad), .bus_chk(bus_chk)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && bus_valid && lg_n < 128) begin
      lg_ad[lg_n]  = bus_ad;
      lg_be[lg_n]  = bus_be;
      lg_chk[lg_n] = bus_chk;
      lg_adr[lg_n] = bus_addr_cyc;
      lg_ln[lg_n]  = bus_line;
      lg_cy[lg_n]  = cyc;
      lg_n = lg_n + 1;
    end
  end

  function automatic logic [7:0] par(input logic [63:0] v);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^v[8*i +: 8];
    return p;
  endfunction

  task automatic ck(input string req, input string what,
                    input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ck_cyc(input int i, input logic adr, input logic [63:0] ad,
                        input logic [7:0] be, input logic ln, input string req);
    ck(req, $sformatf("cycle %0d kind", i), 64'(lg_adr[i]), 64'(adr));
    ck(req, $sformatf("cycle %0d ad", i), lg_ad[i], ad);
    ck(req, $sformatf("cycle %0d be", i), 64'(lg_be[i]), 64'(be));
    ck(req, $sformatf("cycle %0d line", i), 64'(lg_ln[i]), 64'(ln));
    ck("R7", $sformatf("cycle %0d parity", i), 64'(lg_chk[i]), 64'(par(ad)));
  endtask

  task automatic do_reset(input logic wide, input logic [2:0] gap,
                          input logic pipe, input logic rdy);
    @(negedge clk);
    rst = 1'b1; cfg_wide = wide; cfg_gap = gap; cfg_pipe = pipe;
    bus_wr_rdy = rdy; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [63:0] a, input logic [63:0] d,
                      input logic [7:0] be, input logic ln);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d; in_be = be; in_line = ln;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 3'd0, 1'b0, 1'b1);
    @(negedge clk);
    ck("R1", "ready after reset", 64'(in_ready), 64'd1);
    ck("R1", "bus idle after reset", 64'(bus_valid), 64'd0);
  endtask

  task automatic t_single64();
    int b;
    do_reset(1'b1, 3'd0, 1'b0, 1'b1);
    b = lg_n;
    push(64'h0000_0000_0000_1008, 64'h0123_4567_89AB_CDEF, 8'h3C, 1'b0);
    idle(6);
    ck("R4", "cycle count", 64'(lg_n - b), 64'd2);
    ck_cyc(b, 1'b1, 64'h1008, 8'h3C, 1'b0, "R4");
    ck_cyc(b + 1, 1'b0, 64'h0123_4567_89AB_CDEF, 8'h3C, 1'b0, "R4");
    ck("R3", "gap0 spacing", 64'(lg_cy[b+1] - lg_cy[b]), 64'd1);
  endtask

  task automatic t_cfg_gap();
    int b;
    do_reset(1'b1, 3'd4, 1'b0, 1'b1);
    cfg_gap = 3'd0; cfg_wide = 1'b0; cfg_pipe = 1'b1;  // R11: ignored now
    b = lg_n;
    push(64'h2000, 64'hFFEE_DDCC_BBAA_9988, 8'hFF, 1'b0);
    idle(10);
    ck("R11", "still one wide transaction", 64'(lg_n - b), 64'd2);
    ck_cyc(b + 1, 1'b0, 64'hFFEE_DDCC_BBAA_9988, 8'hFF, 1'b0, "R11");
    ck("R3", "gap4 spacing", 64'(lg_cy[b+1] - lg_cy[b]), 64'd5);
  endtask

  task automatic t_back2back();
    int b;
    do_reset(1'b1, 3'd0, 1'b0, 1'b1);
    b = lg_n;
    for (int k = 0; k < 3; k++)
      push(64'h3000 + 64'(8 * k), 64'hA0 + 64'(k), 8'hFF, 1'b0);
    idle(8);
    ck("R10", "cycle count", 64'(lg_n - b), 64'd6);
    for (int k = 0; k < 3; k++) begin
      ck_cyc(b + 2*k, 1'b1, 64'h3000 + 64'(8 * k), 8'hFF, 1'b0, "R2");
      ck_cyc(b + 2*k + 1, 1'b0, 64'hA0 + 64'(k), 8'hFF, 1'b0, "R2");
    end
    ck("R10", "addr spacing 1", 64'(lg_cy[b+2] - lg_cy[b]), 64'd2);
    ck("R10", "addr spacing 2", 64'(lg_cy[b+4] - lg_cy[b+2]), 64'd2);
  endtask

  task automatic t_full();
    int b;
    do_reset(1'b1, 3'd0, 1'b0, 1'b0);
    b = lg_n;
    for (int k = 0; k < 4; k++)
      push(64'h4000 + 64'(8 * k), 64'hB0 + 64'(k), 8'h0F, 1'b0);
    @(negedge clk);
    ck("R1", "ready when full", 64'(in_ready), 64'd0);
    idle(5);
    ck("R8", "no issue while not ready", 64'(lg_n - b), 64'd0);
    bus_wr_rdy = 1'b1;
    idle(12);
    ck("R1", "ready after drain", 64'(in_ready), 64'd1);
    ck("R2", "cycle count", 64'(lg_n - b), 64'd8);
    for (int k = 0; k < 4; k++)
      ck_cyc(b + 2*k + 1, 1'b0, 64'hB0 + 64'(k), 8'h0F, 1'b0, "R2");
  endtask

  task automatic t_line64();
    int b;
    do_reset(1'b1, 3'd2, 1'b0, 1'b1);
    b = lg_n;
    for (int k = 0; k < 4; k++)
      push(64'h5000 + 64'(8 * k), 64'h1111_0000_0000_0000 + 64'(k), 8'hFF, 1'b1);
    idle(10);
    ck("R5", "cycle count", 64'(lg_n - b), 64'd5);
    ck_cyc(b, 1'b1, 64'h5000, 8'hFF, 1'b1, "R5");
    for (int k = 0; k < 4; k++) begin
      ck_cyc(b + 1 + k, 1'b0, 64'h1111_0000_0000_0000 + 64'(k), 8'hFF, 1'b1, "R5");
      ck("R3", "line beat timing", 64'(lg_cy[b+1+k] - lg_cy[b]), 64'(3 + k));
    end
  endtask

  task automatic t_line32();
    int b;
    logic [63:0] d;
    do_reset(1'b0, 3'd0, 1'b0, 1'b1);
    b = lg_n;
    for (int k = 0; k < 4; k++)
      push(64'h6000 + 64'(8 * k), {32'hC0DE_0000 + 32'(k), 32'h0000_F000 + 32'(k)},
           8'hFF, 1'b1);
    idle(14);
    ck("R5", "narrow cycle count", 64'(lg_n - b), 64'd9);
    ck_cyc(b, 1'b1, 64'h6000, 8'h0F, 1'b1, "R5");
    for (int k = 0; k < 8; k++) begin
      d = (k % 2 == 0) ? 64'(32'h0000_F000 + 32'(k / 2))
                       : 64'(32'hC0DE_0000 + 32'(k / 2));
      ck_cyc(b + 1 + k, 1'b0, d, 8'h0F, 1'b1, "R5");
      ck("R5", "narrow beat timing", 64'(lg_cy[b+1+k] - lg_cy[b]), 64'(1 + k));
    end
  endtask

  task automatic t_split32();
    int b;
    do_reset(1'b0, 3'd1, 1'b0, 1'b1);
    b = lg_n;
    push(64'h7000, 64'h8765_4321_DEAD_BEEF, 8'hE7, 1'b0);
    push(64'h7008, 64'h5555_AAAA_1234_5678, 8'h30, 1'b0);
    idle(14);
    ck("R6", "cycle count", 64'(lg_n - b), 64'd6);
    ck_cyc(b,     1'b1, 64'h7000, 8'h07, 1'b0, "R6");
    ck_cyc(b + 1, 1'b0, 64'hDEAD_BEEF, 8'h07, 1'b0, "R6");
    ck_cyc(b + 2, 1'b1, 64'h7004, 8'h0E, 1'b0, "R6");
    ck_cyc(b + 3, 1'b0, 64'h8765_4321, 8'h0E, 1'b0, "R6");
    ck_cyc(b + 4, 1'b1, 64'h700C, 8'h03, 1'b0, "R6");
    ck_cyc(b + 5, 1'b0, 64'h5555_AAAA, 8'h03, 1'b0, "R6");
    ck("R3", "narrow gap1 spacing", 64'(lg_cy[b+1] - lg_cy[b]), 64'd2);
  endtask

  task automatic t_pipe(input logic pipe);
    int b, na;
    do_reset(1'b1, 3'd0, pipe, 1'b0);
    b = lg_n;
    for (int k = 0; k < 3; k++)
      push(64'h8000 + 64'(8 * k), 64'hD0 + 64'(k), 8'hFF, 1'b0);
    idle(3);
    @(negedge clk) bus_wr_rdy = 1'b1;
    @(negedge clk) bus_wr_rdy = 1'b0;
    idle(10);
    na = 0;
    for (int i = b; i < lg_n; i++) if (lg_adr[i]) na++;
    if (pipe) ck("R9", "address cycles with pipelining", 64'(na), 64'd2);
    else      ck("R8", "address cycles without pipelining", 64'(na), 64'd1);
  endtask

  initial begin
    t_reset();
    t_single64();
    t_cfg_gap();
    t_back2back();
    t_full();
    t_line64();
    t_line32();
    t_split32();
    t_pipe(1'b0);
    t_pipe(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule